// File: doc/BRIEF.md
# Performance-State Transition Sequencer

This block moves a processor core from one operating point to another when software asks for it. Each operating point is a pair: a core-to-bus clock multiplier and a voltage code for the external regulator. One code unit is worth 12.5 mV, and a larger code means a higher voltage. The bus clock is never touched. Only the multiplier and the voltage code change.

Software writes a target state number. The sequencer then orders the two changes so that the core never runs faster than its supply allows. When the target is faster, the voltage code climbs one unit at a time and the multiplier switches only once the target code has settled. When the target is slower, the multiplier drops first and the voltage code then walks down one unit at a time.

Each intermediate code is held for a programmable settle time. A fixed relock interval follows every multiplier change. A busy flag covers the whole transition. A write that arrives while busy is held and applied afterwards. Status outputs show the current state, the voltage code and a completion flag.

Top module: `dvfs_seq`

## Requirements
- R1: After reset, stat_state is 0, vid_out and ratio_out hold the state-0 values, busy is 0 and stat_done is 1.
- R2: State s maps to ratio RATIO_BASE + s*RATIO_INC and voltage code VID_BASE + s*VID_INC. Both grow with s, so a larger state number is the faster state. After a transition to s completes, ratio_out, vid_out and stat_state equal these values for s.
- R3: Every change of vid_out is exactly +1 or -1 code unit, which is one 12.5 mV step.
- R4: When moving to a larger state number, vid_out reaches the target code before ratio_out changes. ratio_out changes exactly dwell_cfg+1 cycles after the last voltage step.
- R5: When moving to a smaller state number, ratio_out changes before any voltage step. The first decrease of vid_out comes at least RELOCK_CYCLES cycles after the ratio change.
- R6: Within one transition, consecutive changes of vid_out are exactly dwell_cfg+1 cycles apart.
- R7: ratio_out changes exactly once per transition. On an upward move, busy falls at least RELOCK_CYCLES cycles after that ratio change.
- R8: stat_done is 0 whenever busy is 1, and it returns to 1 when busy falls.
- R9: A write accepted while busy is held in a single slot, where the latest write wins. That slot is started once the current transition has completed.
- R10: A write of the current state leaves busy at 0, leaves vid_out and ratio_out unchanged and keeps stat_done at 1.
- R11: vid_out and ratio_out change only on a clock edge where busy was already 1 in the preceding cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Target-state write strobe |
| wr_state | input | STATE_W | Target state number |
| dwell_cfg | input | DWELL_W | Settle cycles held after each voltage step (interval is dwell_cfg+1) |
| vid_out | output | VID_W | Voltage code to the regulator |
| ratio_out | output | RATIO_W | Core-to-bus clock multiplier |
| busy | output | 1 | Transition in progress |
| stat_state | output | STATE_W | Current operating state |
| stat_done | output | 1 | Last requested transition completed |

## Verification
The bench builds the block with these values:
- four states
- three code units between neighbouring states
- a relock interval of four cycles

With these values, every ordered pair of states, in both directions and with jumps of up to nine steps, is swept with dwell_cfg set to 0 and to 3. This tests the step spacing at its minimum and at a multi-cycle value. A further test sends two writes during a long transition, and checks that the first transition completes and only the last write is applied.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_UP_STEP,
    PH_DN_RATIO,
    PH_RELOCK,
    PH_DN_STEP
  } phase_t;

  // Operating-point arithmetic: value for state idx on a linear ladder.
  function automatic int unsigned op_code(input int unsigned idx,
                                          input int unsigned base,
                                          input int unsigned inc);
    return base + idx * inc;
  endfunction

  function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dvfs_op_table.sv
module dvfs_op_table #(
  parameter int NUM_STATES = 4,
  parameter int STATE_W    = 2,
  parameter int VID_W      = 6,
  parameter int RATIO_W    = 5,
  parameter int VID_BASE   = 20,
  parameter int VID_INC    = 3,
  parameter int RATIO_BASE = 8,
  parameter int RATIO_INC  = 2
) (
  input  logic [STATE_W-1:0] sel,
  output logic [VID_W-1:0]   sel_vid,
  output logic [RATIO_W-1:0] sel_ratio
);
  localparam int LAST = NUM_STATES - 1;

  logic [VID_W-1:0]   vid_tab   [NUM_STATES];
  logic [RATIO_W-1:0] ratio_tab [NUM_STATES];
  logic [STATE_W-1:0] idx;

  for (genvar i = 0; i < NUM_STATES; i++) begin : g_entry
    assign vid_tab[i]   = VID_W'(dvfs_pkg::op_code(i, VID_BASE, VID_INC));
    assign ratio_tab[i] = RATIO_W'(dvfs_pkg::op_code(i, RATIO_BASE, RATIO_INC));
  end

  always_comb begin
    idx = (sel > STATE_W'(LAST)) ? STATE_W'(LAST) : sel;
    sel_vid   = vid_tab[idx];
    sel_ratio = ratio_tab[idx];
  end
endmodule

// File: rtl/dvfs_settle_timer.sv
module dvfs_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (load)     cnt_q <= load_val;
    else if (!expired) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/dvfs_req_slot.sv
module dvfs_req_slot #(
  parameter int STATE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [STATE_W-1:0] wr_state,
  input  logic               take,
  output logic               pend_valid,
  output logic [STATE_W-1:0] pend_state
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_state <= '0;
    end else if (wr_en) begin
      pend_valid <= 1'b1;
      pend_state <= wr_state;
    end else if (take) begin
      pend_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dvfs_seq_ctrl.sv
module dvfs_seq_ctrl
  import dvfs_pkg::*;
#(
  parameter int STATE_W       = 2,
  parameter int VID_W         = 6,
  parameter int RATIO_W       = 5,
  parameter int DWELL_W       = 8,
  parameter int CNT_W         = 8,
  parameter int RELOCK_CYCLES = 4,
  parameter int VID_BASE      = 20,
  parameter int RATIO_BASE    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pend_valid,
  input  logic [STATE_W-1:0] pend_state,
  output logic               take,
  input  logic [VID_W-1:0]   tgt_vid,
  input  logic [RATIO_W-1:0] tgt_ratio,
  input  logic [DWELL_W-1:0] dwell_cfg,
  input  logic               tmr_expired,
  output logic               tmr_load,
  output logic [CNT_W-1:0]   tmr_val,
  output logic [STATE_W-1:0] tgt_state,
  output logic [VID_W-1:0]   vid_q,
  output logic [RATIO_W-1:0] ratio_q,
  output logic [STATE_W-1:0] cur_q,
  output logic               done_q,
  output logic               busy
);
  phase_t phase_q;
  logic   up_q;
  logic   at_vid;
  logic   step_up_ev, step_dn_ev, ratio_ev, finish_ev;

  assign at_vid     = (vid_q == tgt_vid);
  assign busy       = (phase_q != PH_IDLE);
  assign take       = (phase_q == PH_IDLE);
  assign step_up_ev = (phase_q == PH_UP_STEP) && tmr_expired && !at_vid;
  assign step_dn_ev = (phase_q == PH_DN_STEP) && tmr_expired && !at_vid;
  assign ratio_ev   = (phase_q == PH_DN_RATIO) ||
                      ((phase_q == PH_UP_STEP) && tmr_expired && at_vid);
  assign finish_ev  = ((phase_q == PH_RELOCK) && tmr_expired && up_q) ||
                      ((phase_q == PH_DN_STEP) && tmr_expired && at_vid);

  always_comb begin
    tmr_load = step_up_ev || step_dn_ev || ratio_ev;
    tmr_val  = ratio_ev ? CNT_W'(RELOCK_CYCLES) : CNT_W'(dwell_cfg);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      up_q      <= 1'b0;
      cur_q     <= '0;
      tgt_state <= '0;
      vid_q     <= VID_W'(op_code(0, VID_BASE, 0));
      ratio_q   <= RATIO_W'(op_code(0, RATIO_BASE, 0));
      done_q    <= 1'b1;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (pend_valid) begin
            if (pend_state == cur_q) begin
              done_q <= 1'b1;
            end else begin
              tgt_state <= pend_state;
              done_q    <= 1'b0;
              up_q      <= (pend_state > cur_q);
              phase_q   <= (pend_state > cur_q) ? PH_UP_STEP : PH_DN_RATIO;
            end
          end
        end
        PH_UP_STEP: begin
          if (step_up_ev) vid_q <= vid_q + 1'b1;
          if (ratio_ev) begin
            ratio_q <= tgt_ratio;
            phase_q <= PH_RELOCK;
          end
        end
        PH_DN_RATIO: begin
          ratio_q <= tgt_ratio;
          phase_q <= PH_RELOCK;
        end
        PH_RELOCK: begin
          if (tmr_expired && !up_q) phase_q <= PH_DN_STEP;
        end
        PH_DN_STEP: begin
          if (step_dn_ev) vid_q <= vid_q - 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
      if (finish_ev) begin
        cur_q   <= tgt_state;
        done_q  <= 1'b1;
        phase_q <= PH_IDLE;
      end
    end
  end
endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq #(
  parameter int NUM_STATES    = 4,
  parameter int VID_W         = 6,
  parameter int RATIO_W       = 5,
  parameter int DWELL_W       = 8,
  parameter int RELOCK_CYCLES = 4,
  parameter int VID_BASE      = 20,
  parameter int VID_INC       = 3,
  parameter int RATIO_BASE    = 8,
  parameter int RATIO_INC     = 2,
  localparam int STATE_W      = (NUM_STATES > 1) ? $clog2(NUM_STATES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [STATE_W-1:0] wr_state,
  input  logic [DWELL_W-1:0] dwell_cfg,
  output logic [VID_W-1:0]   vid_out,
  output logic [RATIO_W-1:0] ratio_out,
  output logic               busy,
  output logic [STATE_W-1:0] stat_state,
  output logic               stat_done
);
  localparam int RELOCK_W = $clog2(RELOCK_CYCLES + 1);
  localparam int CNT_W    = dvfs_pkg::max_w(DWELL_W, RELOCK_W);

  logic               pend_valid, take;
  logic [STATE_W-1:0] pend_state, tgt_state;
  logic [VID_W-1:0]   tgt_vid;
  logic [RATIO_W-1:0] tgt_ratio;
  logic               tmr_load, tmr_expired;
  logic [CNT_W-1:0]   tmr_val;

  dvfs_req_slot #(.STATE_W(STATE_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_state(wr_state),
    .take(take), .pend_valid(pend_valid), .pend_state(pend_state)
  );

  dvfs_op_table #(
    .NUM_STATES(NUM_STATES), .STATE_W(STATE_W), .VID_W(VID_W), .RATIO_W(RATIO_W),
    .VID_BASE(VID_BASE), .VID_INC(VID_INC), .RATIO_BASE(RATIO_BASE), .RATIO_INC(RATIO_INC)
  ) u_table (
    .sel(tgt_state), .sel_vid(tgt_vid), .sel_ratio(tgt_ratio)
  );

  dvfs_settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  dvfs_seq_ctrl #(
    .STATE_W(STATE_W), .VID_W(VID_W), .RATIO_W(RATIO_W), .DWELL_W(DWELL_W),
    .CNT_W(CNT_W), .RELOCK_CYCLES(RELOCK_CYCLES), .VID_BASE(VID_BASE),
    .RATIO_BASE(RATIO_BASE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pend_valid(pend_valid), .pend_state(pend_state),
    .take(take), .tgt_vid(tgt_vid), .tgt_ratio(tgt_ratio), .dwell_cfg(dwell_cfg),
    .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .tgt_state(tgt_state), .vid_q(vid_out), .ratio_q(ratio_out), .cur_q(stat_state),
    .done_q(stat_done), .busy(busy)
  );
endmodule

// File: rtl/dvfs_seq_chk.sv
module dvfs_seq_chk #(
  parameter int VID_W   = 6,
  parameter int RATIO_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic [VID_W-1:0]   vid,
  input logic [RATIO_W-1:0] ratio,
  input logic [VID_W-1:0]   tgt_vid,
  input logic [RATIO_W-1:0] tgt_ratio
);
  AST_VID_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (vid != $past(vid)) |-> ((vid == $past(vid) + 1'b1) || (vid + 1'b1 == $past(vid)))); // R3

  AST_RATIO_UP_AFTER_VID: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio > $past(ratio)) |-> (vid == tgt_vid)); // R4

  AST_VID_DN_AFTER_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    (vid < $past(vid)) |-> (ratio == tgt_ratio)); // R5

  AST_DONE_LOW_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done); // R8

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> ($stable(vid) && $stable(ratio))); // R11
endmodule

bind dvfs_seq dvfs_seq_chk #(.VID_W(VID_W), .RATIO_W(RATIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(stat_done), .vid(vid_out),
  .ratio(ratio_out), .tgt_vid(tgt_vid), .tgt_ratio(tgt_ratio)
);

// File: tb/tb_dvfs_seq.sv
module tb_dvfs_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NS  = 4;
  localparam int VB  = 20;
  localparam int VI  = 3;
  localparam int RB  = 8;
  localparam int RI  = 2;
  localparam int RLK = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_state = '0;
  logic [7:0] dwell_cfg = '0;
  logic [5:0] vid_out;
  logic [4:0] ratio_out;
  logic       busy;
  logic [1:0] stat_state;
  logic       stat_done;

  int checks = 0;
  int errors = 0;
  int cur = 0;

  dvfs_seq #(
    .NUM_STATES(NS), .VID_W(6), .RATIO_W(5), .DWELL_W(8), .RELOCK_CYCLES(RLK),
    .VID_BASE(VB), .VID_INC(VI), .RATIO_BASE(RB), .RATIO_INC(RI)
  ) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_state(wr_state), .dwell_cfg(dwell_cfg),
    .vid_out(vid_out), .ratio_out(ratio_out), .busy(busy),
    .stat_state(stat_state), .stat_done(stat_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected ladder values, built by accumulation rather than a product.
  function automatic int exp_vid(int s);
    int v = VB;
    for (int k = 0; k < s; k++) v += VI;
    return v;
  endfunction
  function automatic int exp_ratio(int s);
    int r = RB;
    for (int k = 0; k < s; k++) r += RI;
    return r;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_state(int s);
    @(negedge clk);
    wr_state = 2'(s);
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Observe one transition from its start until busy falls.
  task automatic watch(int from, int to, int dw);
    int c = 0, nsteps = 0, bad_dir = 0, bad_int = 0, bad_done = 0;
    int first_step = -1, last_step = -1, ratio_cyc = -1, nratio = 0, end_cyc = -1;
    int pv = int'(vid_out), pr = int'(ratio_out);
    bit up = (to > from);
    while (end_cyc < 0 && c < 2000) begin
      @(negedge clk);
      c++;
      if (busy && stat_done) bad_done++;
      if (int'(vid_out) != pv) begin
        nsteps++;
        if (int'(vid_out) - pv != (up ? 1 : -1)) bad_dir++;
        if (last_step >= 0 && c - last_step != dw + 1) bad_int++;
        if (first_step < 0) first_step = c;
        last_step = c;
      end
      if (int'(ratio_out) != pr) begin
        nratio++;
        ratio_cyc = c;
      end
      pv = int'(vid_out);
      pr = int'(ratio_out);
      if (!busy) end_cyc = c;
    end
    check(end_cyc > 0, "R8 transition ends", end_cyc, 1);
    check(int'(vid_out) == exp_vid(to), "R2 final vid", int'(vid_out), exp_vid(to));
    check(int'(ratio_out) == exp_ratio(to), "R2 final ratio", int'(ratio_out), exp_ratio(to));
    check(int'(stat_state) == to && stat_done, "R8 state/done after", int'(stat_state), to);
    check(bad_done == 0, "R8 done low while busy", bad_done, 0);
    check(bad_dir == 0 && nsteps == VI * (up ? to - from : from - to),
          "R3 unit steps", nsteps, VI * (up ? to - from : from - to));
    check(bad_int == 0, "R6 step spacing", bad_int, 0);
    check(nratio == 1, "R7 single ratio change", nratio, 1);
    if (up) begin
      check(ratio_cyc - last_step == dw + 1, "R4 ratio after last up step",
            ratio_cyc - last_step, dw + 1);
      check(end_cyc - ratio_cyc >= RLK, "R7 relock before completion",
            end_cyc - ratio_cyc, RLK);
    end else begin
      check(first_step - ratio_cyc >= RLK, "R5 ratio before first down step",
            first_step - ratio_cyc, RLK);
    end
  endtask

  task automatic move(int to, int dw);
    dwell_cfg = 8'(dw);
    write_state(to);
    if (to == cur) begin
      int v0 = int'(vid_out), r0 = int'(ratio_out), bz = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (busy || int'(vid_out) != v0 || int'(ratio_out) != r0 || !stat_done) bz++;
      end
      check(bz == 0, "R10 same-state write quiet", bz, 0);
    end else begin
      watch(cur, to, dw);
      cur = to;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(int'(vid_out) == exp_vid(0), "R1 reset vid", int'(vid_out), exp_vid(0));
    check(int'(ratio_out) == exp_ratio(0), "R1 reset ratio", int'(ratio_out), exp_ratio(0));
    check(!busy && stat_done && stat_state == 2'd0, "R1 reset flags", int'(busy), 0);

    // Sweep every ordered pair under two dwell settings (R2..R8, R10)
    for (int dw = 0; dw <= 3; dw += 3) begin
      for (int a = 0; a < NS; a++) begin
        for (int b = 0; b < NS; b++) begin
          move(a, dw);
          move(b, dw);
        end
      end
    end

    // R9: writes during a transition; the latest is applied afterwards
    move(0, 2);
    dwell_cfg = 8'd2;
    write_state(3);
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R9 busy during first move", int'(busy), 1);
    write_state(1);
    write_state(2);
    begin
      int c = 0;
      while (busy && c < 2000) begin @(negedge clk); c++; end
    end
    check(int'(stat_state) == 3, "R9 first move completed", int'(stat_state), 3);
    check(int'(ratio_out) == exp_ratio(3), "R9 first move ratio", int'(ratio_out), exp_ratio(3));
    begin
      int c = 0;
      while (!busy && c < 5) begin @(negedge clk); c++; end
      check(busy == 1'b1, "R9 held write started", int'(busy), 1);
      c = 0;
      while (busy && c < 2000) begin @(negedge clk); c++; end
    end
    check(int'(stat_state) == 2, "R9 latest write applied", int'(stat_state), 2);
    check(int'(vid_out) == exp_vid(2), "R9 final vid", int'(vid_out), exp_vid(2));
    repeat (4) @(negedge clk);
    check(!busy && int'(stat_state) == 2, "R9 no extra transition", int'(stat_state), 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule